// File: doc/BRIEF.md
# Serial Conversion Result Output Port

This block is the digital output end of a slow delta-sigma style converter. A small built-in conversion timer stands in for the modulator and filter. When the timer runs out, the block captures a sign flag and a 21-bit magnitude field from its sample inputs. It then offers them to an external host as a 24-bit frame on one serial data line. The host selects the port with an active-low chip select and clocks bits out with its own serial clock. Both host signals are brought into the system clock domain through synchronisers before they are used.

While the port is selected and no bit has yet been clocked, the data line shows a live busy flag. The flag is high while a conversion runs and drops as soon as a fresh result is held. Each falling serial clock edge moves the frame on by one position: first a constant zero, then the sign, then the result from its top bit down. The 24th falling edge ends the frame. It drives the line high, which is the busy flag of the next frame, and it starts a new conversion. When chip select is high, the output enable is low and the serial clock has no effect.

Top module: `adcso_serial_out`

## Requirements
- R1: While chip select (`csN`) is high, `sdoOe` is 0, and serial clock edges do not move the frame position. The next selected frame starts again from its first bit.
- R2: While `csN` is low and no falling edge has yet been taken in the frame, `sdo` shows the busy flag (1 = converting, 0 = result ready). The flag falls while select is held low, once the conversion completes.
- R3: Frame bit positions run MSB first. Bit 23 is the busy flag and bit 22 is a constant 0. Bit 21 is `sampleSign`, and bits 20..0 are `sampleData[20:0]`. Bit 22 appears after the 1st falling edge and bit 0 after the 23rd.
- R4: After the 24th falling edge, `sdo` is 1 and a new conversion starts, so the flag stays high until that conversion ends.
- R5: A conversion that completes while a frame is part-way out does not change the bits still to come. The result is taken in only once the frame position is back at its start.
- R6: Raising `csN` in mid-frame returns the frame to its start. On the next selection `sdo` shows the busy flag, and the whole frame follows from bit 22.
- R7: A conversion lasts `convCycles` system clocks from its start. The first one starts just after reset.
- R8: The sign and the top result bit pass through unchanged, so the over-range codes reach the host. Bits 21:20 equal to 11 mean above positive full scale, and 00 mean below negative full scale.
- R9: After reset, `sdoOe` is 0 and a conversion is in progress.
- R10: A rising serial clock edge does not change `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Host serial clock (asynchronous) |
| csN | input | 1 | Host chip select, active low (asynchronous) |
| convCycles | input | 16 | Conversion length in system clocks |
| sampleSign | input | 1 | Sign flag from the conversion stub |
| sampleData | input | 21 | Result field from the conversion stub |
| sdo | output | 1 | Serial data value |
| sdoOe | output | 1 | Output enable for the serial data pad (0 = high impedance) |

## Verification
The hardest situation to reach is a conversion that finishes while a frame is part-way out. The host must start reading while the busy flag is still high, so the frame shows the previous result. The stimulus reaches it by selecting the port straight after a 24-edge readout, while the new conversion is still running. It then clocks twelve bits slowly enough that the timer expires in the middle. It checks that those bits still belong to the old result, and aborts with chip select. It then expects the flag to read ready at once and the new result to follow in full.

// File: rtl/adcso_pkg.sv
package adcso_pkg;

  // Strobes the control side sends to the datapath each system clock.
  typedef struct packed {
    logic loadResult;  // capture a fresh conversion into the hold register
    logic loadShift;   // copy the hold register into the shifter
    logic shiftOne;    // advance the shifter by one bit
    logic showData;    // serial line carries shifter data rather than the flag
  } frameStrobes_t;

endpackage

// File: rtl/adcso_conv_timer.sv
module adcso_conv_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startConv,
  input  logic [CNT_W-1:0] convCycles,
  output logic             convDone
);

  logic [CNT_W-1:0] count;
  logic             running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      running <= 1'b0;
    end else if (startConv) begin
      count   <= (convCycles == '0) ? CNT_W'(1) : convCycles;
      running <= 1'b1;
    end else if (running) begin
      count <= count - CNT_W'(1);
      if (count == CNT_W'(1)) running <= 1'b0;
    end
  end

  assign convDone = running && (count == CNT_W'(1)) && !startConv;

  // R7: the done pulse lasts one clock
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);

  // R7: a start always leaves the timer running with a nonzero count
  assert_restart_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    startConv |=> (running && count != '0));

endmodule

// File: rtl/adcso_frame_ctrl.sv
module adcso_frame_ctrl
  import adcso_pkg::*;
#(
  parameter int RESULT_W    = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sckIn,
  input  logic          csN,
  input  logic          convDone,
  output frameStrobes_t strobes,
  output logic          restartConv,
  output logic          eocLevel,
  output logic          sdoOe
);

  localparam int FRAME_BITS = RESULT_W + 3;
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);

  logic [SYNC_STAGES-1:0] sckPipe;
  logic [SYNC_STAGES-1:0] csPipe;
  logic                   sckPrev;
  logic                   sckFall;
  logic                   csHigh;
  logic [CW-1:0]          bitCount;
  logic                   pending;
  logic                   dataReady;
  logic                   bootKick;
  logic                   frameEnd;
  logic                   atStart;

  // two or more flops on each host input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      csPipe  <= '1;
      sckPrev <= 1'b0;
    end else begin
      sckPipe <= {sckPipe[SYNC_STAGES-2:0], sckIn};
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csN};
      sckPrev <= sckPipe[SYNC_STAGES-1];
    end
  end

  assign csHigh   = csPipe[SYNC_STAGES-1];
  assign sckFall  = sckPrev && !sckPipe[SYNC_STAGES-1] && !csHigh;
  assign atStart  = (bitCount == '0);
  assign frameEnd = sckFall && (bitCount == LAST_POS);

  // frame position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        bitCount <= '0;
    else if (csHigh)  bitCount <= '0;
    else if (sckFall) bitCount <= frameEnd ? '0 : bitCount + CW'(1);
  end

  // one-shot start of the first conversion after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bootKick <= 1'b1;
    else       bootKick <= 1'b0;
  end

  assign restartConv = frameEnd || bootKick;

  // completed conversion waits here until the frame is back at its start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      dataReady <= 1'b0;
    end else if (restartConv) begin
      pending   <= 1'b0;
      dataReady <= 1'b0;
    end else if (strobes.loadResult) begin
      pending   <= 1'b0;
      dataReady <= 1'b1;
    end else if (convDone) begin
      pending   <= 1'b1;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.loadResult = pending && atStart && !restartConv;
    strobes.loadShift  = atStart;
    strobes.shiftOne   = sckFall && !atStart && !frameEnd;
    strobes.showData   = !atStart;
  end

  assign eocLevel = !dataReady;
  assign sdoOe    = !csHigh;

  // R6: a deselect puts the frame back at its first position
  assert_abort_resets_R6: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> (bitCount == '0));

  // R3: the frame position never passes the last bit
  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= LAST_POS);

  // R4: the end of a frame shows busy on the next clock
  assert_busy_after_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (eocLevel && atStart));

endmodule

// File: rtl/adcso_frame_datapath.sv
module adcso_frame_datapath
  import adcso_pkg::*;
#(
  parameter int RESULT_W = 21
) (
  input  logic                clk,
  input  logic                rstN,
  input  frameStrobes_t       strobes,
  input  logic                eocLevel,
  input  logic                sampleSign,
  input  logic [RESULT_W-1:0] sampleData,
  output logic                sdo
);

  // dummy bit, sign bit and result field
  localparam int HOLD_W = RESULT_W + 2;

  logic [HOLD_W-1:0] resultReg;
  logic [HOLD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   resultReg <= '0;
    else if (strobes.loadResult) resultReg <= {1'b0, sampleSign, sampleData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  shiftReg <= '0;
    else if (strobes.loadShift) shiftReg <= resultReg;
    else if (strobes.shiftOne)  shiftReg <= {shiftReg[HOLD_W-2:0], 1'b0};
  end

  assign sdo = strobes.showData ? shiftReg[HOLD_W-1] : eocLevel;

  // R5: the shifter keeps its contents while the frame is in flight
  assert_shift_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.showData && !strobes.shiftOne && !strobes.loadShift) |=> $stable(shiftReg));

endmodule

// File: rtl/adcso_serial_out.sv
module adcso_serial_out
  import adcso_pkg::*;
#(
  parameter int RESULT_W    = 21,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sckIn,
  input  logic                csN,
  input  logic [CNT_W-1:0]    convCycles,
  input  logic                sampleSign,
  input  logic [RESULT_W-1:0] sampleData,
  output logic                sdo,
  output logic                sdoOe
);

  frameStrobes_t strobes;
  logic          restartConv;
  logic          convDone;
  logic          eocLevel;

  adcso_conv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rstN       (rstN),
    .startConv  (restartConv),
    .convCycles (convCycles),
    .convDone   (convDone)
  );

  adcso_frame_ctrl #(.RESULT_W(RESULT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sckIn       (sckIn),
    .csN         (csN),
    .convDone    (convDone),
    .strobes     (strobes),
    .restartConv (restartConv),
    .eocLevel    (eocLevel),
    .sdoOe       (sdoOe)
  );

  adcso_frame_datapath #(.RESULT_W(RESULT_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .eocLevel   (eocLevel),
    .sampleSign (sampleSign),
    .sampleData (sampleData),
    .sdo        (sdo)
  );

endmodule

// File: tb/adcso_serial_out_bench.sv
module adcso_serial_out_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sckIn = 1'b0;
  logic        csN = 1'b1;
  logic [15:0] convCycles = 16'd64;
  logic        sampleSign = 1'b0;
  logic [20:0] sampleData = '0;
  logic        sdo;
  logic        sdoOe;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adcso_serial_out u_adcso_serial_out (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csN(csN), .convCycles(convCycles),
    .sampleSign(sampleSign), .sampleData(sampleData), .sdo(sdo), .sdoOe(sdoOe)
  );

  // {sign, data}; first two are the over-range codes
  localparam logic [21:0] VEC [0:5] = '{22'h3FFFFF, 22'h000000, 22'h200000,
                                         22'h1FFFFF, 22'h155555, 22'h2AAAAA};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setSample(input logic [21:0] v);
    sampleSign = v[21];
    sampleData = v[20:0];
  endtask

  task automatic waitReady(input string tag);
    int n = 0;
    csN = 1'b0;
    tick(6);
    while (sdo !== 1'b0 && n < 600) begin
      tick(1);
      n++;
    end
    chk(tag, {31'd0, sdo}, 32'd0);
  endtask

  // caller has held select low long enough for the flag to be visible
  task automatic readFrame(output logic [23:0] w, output logic endBit);
    w[23] = sdo;
    endBit = 1'b0;
    for (int k = 1; k <= 24; k++) begin
      sckIn = 1'b1; tick(6);
      sckIn = 1'b0; tick(6);
      if (k < 24) w[23-k] = sdo;
      else endBit = sdo;
    end
  endtask

  initial begin
    logic [23:0] w;
    logic        e;
    logic [22:0] oldW;
    logic [11:0] part;
    int          n;

    // R9: reset state
    setSample(VEC[0]);
    tick(5);
    chk("R9 oe in reset", {31'd0, sdoOe}, 32'd0);
    rstN = 1'b1;
    n = 0;
    tick(3); n += 3;
    csN = 1'b0;
    tick(6); n += 6;
    chk("R9 oe selected", {31'd0, sdoOe}, 32'd1);
    chk("R2 busy flag", {31'd0, sdo}, 32'd1);
    while (sdo !== 1'b0 && n < 600) begin tick(1); n++; end
    chk("R2 flag fell live", {31'd0, sdo}, 32'd0);
    chk("R7 conversion length", {31'd0, (n >= 60 && n <= 72)}, 32'd1);
    csN = 1'b1;
    tick(6);

    // table of results walked by one loop
    for (int i = 0; i < 6; i++) begin
      waitReady("R2 ready");
      readFrame(w, e);
      chk((i < 2) ? "R8 range code frame" : "R3 frame", {8'd0, w}, {8'd0, 2'b00, VEC[i]});
      chk("R4 end bit high", {31'd0, e}, 32'd1);
      setSample(VEC[(i + 1) % 6]);
      tick(2);
      chk("R4 busy after frame", {31'd0, sdo}, 32'd1);
      csN = 1'b1;
      tick(6);
    end

    // R1: clocks while deselected are ignored
    for (int k = 0; k < 10; k++) begin
      sckIn = 1'b1; tick(6);
      sckIn = 1'b0; tick(6);
    end
    chk("R1 hi-z while deselected", {31'd0, sdoOe}, 32'd0);
    waitReady("R1 ready");
    readFrame(w, e);
    chk("R1 frame from start", {8'd0, w}, {8'd0, 2'b00, VEC[0]});
    setSample(22'h2AAAAA);
    csN = 1'b1;
    tick(6);

    // R10 and R6: partial frame, then abort
    waitReady("R6 ready");
    sckIn = 1'b1; tick(6);
    sckIn = 1'b0; tick(6);
    chk("R3 dummy bit", {31'd0, sdo}, 32'd0);
    sckIn = 1'b1; tick(6);
    chk("R10 rising edge holds", {31'd0, sdo}, 32'd0);
    sckIn = 1'b0; tick(6);
    chk("R3 sign bit", {31'd0, sdo}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      sckIn = 1'b1; tick(6);
      sckIn = 1'b0; tick(6);
    end
    csN = 1'b1;
    tick(6);
    chk("R1 hi-z after abort", {31'd0, sdoOe}, 32'd0);
    csN = 1'b0;
    tick(6);
    chk("R6 flag after abort", {31'd0, sdo}, 32'd0);
    readFrame(w, e);
    chk("R6 full frame after abort", {8'd0, w}, {8'd0, 2'b00, 22'h2AAAAA});
    setSample(22'h0F0F0F);

    // R5: conversion ends during a frame begun while busy
    tick(2);
    chk("R5 busy at start", {31'd0, sdo}, 32'd1);
    oldW = {1'b0, 22'h2AAAAA};
    for (int k = 0; k < 12; k++) begin
      sckIn = 1'b1; tick(6);
      sckIn = 1'b0; tick(6);
      part[11-k] = sdo;
    end
    chk("R5 old bits kept", {20'd0, part}, {20'd0, oldW[22:11]});
    csN = 1'b1;
    tick(6);
    csN = 1'b0;
    tick(6);
    chk("R5 ready after abort", {31'd0, sdo}, 32'd0);
    readFrame(w, e);
    chk("R5 new result", {8'd0, w}, {8'd0, 2'b00, 22'h0F0F0F});
    csN = 1'b1;
    tick(4);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule